// File: doc/BRIEF.md
# Power Fault Interrupt Collector

This block gathers eight classes of power-supply fault into one level interrupt for a host processor. Each class has a group of fault-condition inputs, one wire per source. A source whose condition is present sets a sticky bit in that class's sub-status register. Each class then reports one bit in a main status register, and the main status bits that the main mask leaves open drive the interrupt line.

The interrupt follows the standing fault, not the moment the fault starts. A latched bit clears only when software acknowledges it and its condition has also gone away. While the condition is still present, an acknowledge has no effect and the line stays high. Only the thermal class and the system class have a sub-mask. The other six classes cannot be masked below the main mask.

Software reaches all registers through a plain byte-wide register port. Writes take effect on a clock edge. Reads are combinational from the address. The port has no back-pressure: every write is taken in the cycle it is presented.

Top module: `faultirq_aggregator`

## Requirements
- R1: After reset every sub-status, sub-mask, main status and main mask bit is 0, and `irq` is low.
- R2: A source whose condition input is high at a clock edge sets its sub-status bit at that edge. Sources outside a class's valid set never set and always read 0. For the over-voltage-detect class (class 4, address 0x28) the valid set is 0x2F. For the under-voltage-detect class (class 5, address 0x29) it is 0x6F. All other classes accept all eight sources.
- R3: Main status bit k (address 0x30) is 1 when class k has at least one sub-status bit set that its sub-mask leaves open. The classes map to bits as follows: thermal 0, over-voltage protect 1, short-circuit 2, over-current 3, over-voltage detect 4, under-voltage detect 5, under-voltage protect 6, system 7.
- R4: `irq` is high exactly when some main status bit is 1 and the matching bit of the main mask (address 0x31, read/write) is 0. Writing 0xFF to the main mask silences every class.
- R5: A sub-status bit stays set after its condition clears, until it is acknowledged. Without a register write, `irq` never falls.
- R6: Writing a 1 to bit k of the main status register acknowledges every sub-status bit of class k. Writing 0 to a bit has no effect.
- R7: Sub-status registers are write-one-to-clear. The thermal class is at 0x23, and classes 1 to 7 are at 0x25 to 0x2B in class order.
- R8: An acknowledge, whether through R6 or R7, does not clear a bit whose condition is still high. Such a bit reads 1 after the write, and `irq` stays high.
- R9: Only the thermal class (sub-mask at 0x24) and the system class (sub-mask at 0x2C) have sub-masks. A sub-mask bit set to 1 keeps that sub-status bit out of the main status bit, but the sub-status bit still latches. Both sub-masks are read/write and reset to 0.
- R10: Unmapped addresses read 0, and writes to them change no register.
- R11: The main mask changes only `irq`. Main status reads are the same whether or not a class is masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 8 | Register address |
| reg_wen | input | 1 | Write strobe; the write happens at the next rising edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| fault_cond | input | 64 | Fault condition inputs; class k uses bits 8k+7 to 8k |
| irq | output | 1 | Level interrupt to the host |

## Verification
The bench exercises four fault patterns, and each one separates a pair of behaviours the block must not confuse:

- **Pulse then acknowledge.** A single fault pulses and is then acknowledged. This separates sticky latching from a pass-through of the input.
- **Acknowledge while held.** A fault stays high through its acknowledge. This separates the level-held rule from plain write-one-to-clear.
- **All sources at once.** All eight sources of the two voltage-detect classes are driven together. This shows that only the valid sources latch.
- **One class at a time.** Each class is raised alone. This pins the main status bit order.

Masking is tried at both levels: the main mask, and the sub-masks of the thermal and system classes. The bench also writes the mask address a class would have if it had one. This shows the unmaskable classes still reach the interrupt.

// File: rtl/faultirq_pkg.sv
package faultirq_pkg;

  localparam int FI_NUM_CLASS = 8;
  localparam int FI_SRC_W     = 8;
  localparam int FI_ADDR_W    = 8;
  localparam int FI_DATA_W    = 8;

  // Register addresses (fixed map; software depends on them)
  localparam logic [7:0] FI_A_THERM_STAT = 8'h23;
  localparam logic [7:0] FI_A_THERM_MASK = 8'h24;
  localparam logic [7:0] FI_A_SUB_BASE   = 8'h24; // class k >= 1 at base + k
  localparam logic [7:0] FI_A_SYS_MASK   = 8'h2C;
  localparam logic [7:0] FI_A_MAIN_STAT  = 8'h30;
  localparam logic [7:0] FI_A_MAIN_MASK  = 8'h31;

  // Class indices, also the main status bit positions
  typedef enum int {
    FI_THERM = 0,
    FI_OVP   = 1,
    FI_SCP   = 2,
    FI_OCP   = 3,
    FI_OVD   = 4,
    FI_UVD   = 5,
    FI_UVP   = 6,
    FI_SYS   = 7
  } fi_class_e;

  // Sources that exist in each class
  function automatic logic [7:0] fi_valid_src(int k);
    case (k)
      FI_OVD:  return 8'h2F;
      FI_UVD:  return 8'h6F;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic bit fi_has_submask(int k);
    return (k == FI_THERM) || (k == FI_SYS);
  endfunction

  function automatic logic [7:0] fi_stat_addr(int k);
    if (k == FI_THERM) return FI_A_THERM_STAT;
    return FI_A_SUB_BASE + 8'(k);
  endfunction

  function automatic logic [7:0] fi_mask_addr(int k);
    if (k == FI_THERM) return FI_A_THERM_MASK;
    return FI_A_SYS_MASK;
  endfunction

endpackage

// File: rtl/faultirq_class.sv
// One fault class: sticky sub-status with level-held acknowledge,
// optional sub-mask, and the class summary bit.
module faultirq_class #(
  parameter int               SRC_W    = 8,
  parameter logic [SRC_W-1:0] VALID    = '1,
  parameter bit               HAS_MASK = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_W-1:0] cond,
  input  logic [SRC_W-1:0] stat_clr,
  input  logic             mask_we,
  input  logic [SRC_W-1:0] mask_wdata,
  output logic [SRC_W-1:0] sub_stat,
  output logic [SRC_W-1:0] sub_mask,
  output logic             pending
);

  logic [SRC_W-1:0] stat_q;
  logic [SRC_W-1:0] set_vec;

  // A live condition dominates any acknowledge in the same cycle
  assign set_vec = cond & VALID;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else begin
      stat_q <= (stat_q & ~stat_clr) | set_vec;
    end
  end

  generate
    if (HAS_MASK) begin : g_mask
      logic [SRC_W-1:0] mask_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          mask_q <= '0;
        end else if (mask_we) begin
          mask_q <= mask_wdata;
        end
      end
      assign sub_mask = mask_q;
    end else begin : g_nomask
      logic unused_mask_in;
      assign unused_mask_in = mask_we ^ (^mask_wdata);
      assign sub_mask = '0;
    end
  endgenerate

  assign sub_stat = stat_q;
  assign pending  = |(stat_q & ~sub_mask);

endmodule

// File: rtl/faultirq_regfile.sv
// Address decode: write strobes toward the classes and main mask, read mux.
module faultirq_regfile
  import faultirq_pkg::*;
#(
  parameter int NUM_CLASS = 8,
  parameter int SRC_W     = 8,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8
) (
  input  logic [ADDR_W-1:0]                 reg_addr,
  input  logic                              reg_wen,
  input  logic [DATA_W-1:0]                 reg_wdata,
  input  logic [NUM_CLASS-1:0][SRC_W-1:0]   sub_stat,
  input  logic [NUM_CLASS-1:0][SRC_W-1:0]   sub_mask,
  input  logic [NUM_CLASS-1:0]              main_stat,
  input  logic [NUM_CLASS-1:0]              main_mask,
  output logic [NUM_CLASS-1:0][SRC_W-1:0]   stat_clr,
  output logic [NUM_CLASS-1:0]              mask_we,
  output logic                              main_mask_we,
  output logic [DATA_W-1:0]                 reg_rdata
);

  logic [7:0] addr8;
  logic       main_ack;

  assign addr8        = 8'(reg_addr);
  assign main_ack     = reg_wen && (addr8 == FI_A_MAIN_STAT);
  assign main_mask_we = reg_wen && (addr8 == FI_A_MAIN_MASK);

  // Per-class write strobes
  always_comb begin
    for (int k = 0; k < NUM_CLASS; k++) begin
      stat_clr[k] = '0;
      if (reg_wen && addr8 == fi_stat_addr(k)) begin
        stat_clr[k] = SRC_W'(reg_wdata);
      end
      if (main_ack && reg_wdata[k]) begin
        stat_clr[k] = '1;
      end
      mask_we[k] = reg_wen && fi_has_submask(k) && (addr8 == fi_mask_addr(k));
    end
  end

  // Read mux; unmapped addresses read zero
  always_comb begin
    reg_rdata = '0;
    if (addr8 == FI_A_MAIN_STAT) reg_rdata = DATA_W'(main_stat);
    if (addr8 == FI_A_MAIN_MASK) reg_rdata = DATA_W'(main_mask);
    for (int k = 0; k < NUM_CLASS; k++) begin
      if (addr8 == fi_stat_addr(k)) begin
        reg_rdata = DATA_W'(sub_stat[k]);
      end
      if (fi_has_submask(k) && addr8 == fi_mask_addr(k)) begin
        reg_rdata = DATA_W'(sub_mask[k]);
      end
    end
  end

endmodule

// File: rtl/faultirq_mainmask.sv
// Main mask register and interrupt gating.
module faultirq_mainmask #(
  parameter int NUM_CLASS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mask_we,
  input  logic [NUM_CLASS-1:0] mask_wdata,
  input  logic [NUM_CLASS-1:0] main_stat,
  output logic [NUM_CLASS-1:0] main_mask,
  output logic                 irq
);

  logic [NUM_CLASS-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_we) begin
      mask_q <= mask_wdata;
    end
  end

  assign main_mask = mask_q;
  assign irq       = |(main_stat & ~mask_q);

endmodule

// File: rtl/faultirq_aggregator.sv
module faultirq_aggregator
  import faultirq_pkg::*;
#(
  parameter int NUM_CLASS = FI_NUM_CLASS,
  parameter int SRC_W     = FI_SRC_W,
  parameter int ADDR_W    = FI_ADDR_W,
  parameter int DATA_W    = FI_DATA_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          reg_addr,
  input  logic                       reg_wen,
  input  logic [DATA_W-1:0]          reg_wdata,
  output logic [DATA_W-1:0]          reg_rdata,
  input  logic [NUM_CLASS*SRC_W-1:0] fault_cond,
  output logic                       irq
);

  logic [NUM_CLASS-1:0][SRC_W-1:0] sub_stat;
  logic [NUM_CLASS-1:0][SRC_W-1:0] sub_mask;
  logic [NUM_CLASS-1:0][SRC_W-1:0] stat_clr;
  logic [NUM_CLASS-1:0]            mask_we;
  logic [NUM_CLASS-1:0]            main_stat;
  logic [NUM_CLASS-1:0]            main_mask;
  logic                            main_mask_we;

  generate
    for (genvar k = 0; k < NUM_CLASS; k++) begin : g_class
      faultirq_class #(
        .SRC_W   (SRC_W),
        .VALID   (SRC_W'(fi_valid_src(k))),
        .HAS_MASK(fi_has_submask(k))
      ) u_class (
        .clk       (clk),
        .rst_n     (rst_n),
        .cond      (fault_cond[k*SRC_W +: SRC_W]),
        .stat_clr  (stat_clr[k]),
        .mask_we   (mask_we[k]),
        .mask_wdata(SRC_W'(reg_wdata)),
        .sub_stat  (sub_stat[k]),
        .sub_mask  (sub_mask[k]),
        .pending   (main_stat[k])
      );
    end
  endgenerate

  faultirq_regfile #(
    .NUM_CLASS(NUM_CLASS),
    .SRC_W    (SRC_W),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W)
  ) u_regs (
    .reg_addr    (reg_addr),
    .reg_wen     (reg_wen),
    .reg_wdata   (reg_wdata),
    .sub_stat    (sub_stat),
    .sub_mask    (sub_mask),
    .main_stat   (main_stat),
    .main_mask   (main_mask),
    .stat_clr    (stat_clr),
    .mask_we     (mask_we),
    .main_mask_we(main_mask_we),
    .reg_rdata   (reg_rdata)
  );

  faultirq_mainmask #(
    .NUM_CLASS(NUM_CLASS)
  ) u_main (
    .clk       (clk),
    .rst_n     (rst_n),
    .mask_we   (main_mask_we),
    .mask_wdata(NUM_CLASS'(reg_wdata)),
    .main_stat (main_stat),
    .main_mask (main_mask),
    .irq       (irq)
  );

endmodule

// File: rtl/faultirq_checks.sv
module faultirq_checks #(
  parameter int NUM_CLASS = 8,
  parameter int SRC_W     = 8,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic [ADDR_W-1:0]               reg_addr,
  input logic                            reg_wen,
  input logic [DATA_W-1:0]               reg_wdata,
  input logic [NUM_CLASS*SRC_W-1:0]      fault_cond,
  input logic                            irq,
  input logic [NUM_CLASS-1:0]            main_stat,
  input logic [NUM_CLASS-1:0]            main_mask,
  input logic [NUM_CLASS-1:0][SRC_W-1:0] sub_stat
);

  // R1: reset leaves the line quiet
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> !irq);

  // R2/R3: an unmaskable class (over-voltage protect) reports a live condition
  a_r2_ovp_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (|fault_cond[2*SRC_W-1:SRC_W]) |=> main_stat[1]);

  // R2: under-voltage-detect sources outside 0x6F never latch
  a_r2_uvd_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_stat[5] & ~SRC_W'(8'h6F)) == '0);

  // R4: a fully closed main mask silences the line
  a_r4_mask_all: assert property (@(posedge clk) disable iff (!rst_n)
    (&main_mask) |-> !irq);

  // R5: without a register write the line cannot fall
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !reg_wen) |=> irq);

  // R6: acknowledge of an idle class clears its main bit
  a_r6_ack_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wen && reg_addr == ADDR_W'(8'h30) && reg_wdata[1]
     && fault_cond[2*SRC_W-1:SRC_W] == '0) |=> !main_stat[1]);

endmodule

bind faultirq_aggregator faultirq_checks #(
  .NUM_CLASS(NUM_CLASS),
  .SRC_W    (SRC_W),
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W)
) u_checks (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_addr  (reg_addr),
  .reg_wen   (reg_wen),
  .reg_wdata (reg_wdata),
  .fault_cond(fault_cond),
  .irq       (irq),
  .main_stat (main_stat),
  .main_mask (main_mask),
  .sub_stat  (sub_stat)
);

// File: tb/faultirq_aggregator_test.sv
`timescale 1ns/1ps
module faultirq_aggregator_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_wen = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [63:0] fault_cond = '0;
  logic        irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  faultirq_aggregator uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wen   (reg_wen),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .fault_cond(fault_cond),
    .irq       (irq)
  );

  task automatic check(string req, logic [7:0] got, logic [7:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    reg_addr  = a;
    reg_wdata = d;
    reg_wen   = 1'b1;
    @(negedge clk);
    reg_wen   = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic set_class(int k, logic [7:0] v);
    fault_cond[k*8 +: 8] = v;
  endtask

  task automatic cleanup();
    fault_cond = '0;
    step();
    wr(8'h30, 8'hFF);
    wr(8'h31, 8'h00);
    wr(8'h24, 8'h00);
    wr(8'h2C, 8'h00);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(8'h30, d); check("R1 main status", d, 8'h00);
    rd(8'h31, d); check("R1 main mask", d, 8'h00);
    rd(8'h23, d); check("R1 thermal status", d, 8'h00);
    rd(8'h2C, d); check("R1 system mask", d, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_pulse_ack();
    logic [7:0] d;
    step();
    set_class(0, 8'h01);
    step();
    rd(8'h23, d); check("R2 thermal latch", d, 8'h01);
    check("R4 irq raised", {7'd0, irq}, 8'h01);
    set_class(0, 8'h00);
    step(); step();
    rd(8'h23, d); check("R5 sticky after clear", d, 8'h01);
    check("R5 irq held", {7'd0, irq}, 8'h01);
    wr(8'h30, 8'h00);
    rd(8'h23, d); check("R6 zero write no effect", d, 8'h01);
    wr(8'h30, 8'h01);
    rd(8'h23, d); check("R6 ack clears", d, 8'h00);
    check("R6 irq dropped", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_ack_held();
    logic [7:0] d;
    step();
    set_class(3, 8'h04);
    step();
    wr(8'h30, 8'h08);
    rd(8'h27, d); check("R8 main ack while held", d, 8'h04);
    check("R8 irq stays", {7'd0, irq}, 8'h01);
    wr(8'h27, 8'h04);
    rd(8'h27, d); check("R8 sub ack while held", d, 8'h04);
    cleanup();
    rd(8'h27, d); check("R8 clears once idle", d, 8'h00);
  endtask

  task automatic t_sub_w1c();
    logic [7:0] d;
    step();
    set_class(1, 8'h03);
    step();
    set_class(1, 8'h00);
    step();
    wr(8'h25, 8'h01);
    rd(8'h25, d); check("R7 single bit cleared", d, 8'h02);
    rd(8'h30, d); check("R7 main bit remains", d, 8'h02);
    wr(8'h25, 8'h02);
    check("R7 irq after last clear", {7'd0, irq}, 8'h00);
    cleanup();
  endtask

  task automatic t_valid_src();
    logic [7:0] d;
    step();
    set_class(4, 8'hFF);
    set_class(5, 8'hFF);
    step();
    rd(8'h28, d); check("R2 over-voltage detect valid", d, 8'h2F);
    rd(8'h29, d); check("R2 under-voltage detect valid", d, 8'h6F);
    cleanup();
    set_class(5, 8'h90);
    step(); step();
    rd(8'h29, d); check("R2 invalid only", d, 8'h00);
    check("R2 invalid no irq", {7'd0, irq}, 8'h00);
    cleanup();
  endtask

  task automatic t_bit_order();
    logic [7:0] d;
    for (int k = 0; k < 8; k++) begin
      step();
      set_class(k, 8'h01);
      step();
      rd(8'h30, d); check("R3 class bit position", d, 8'(1 << k));
      cleanup();
    end
  endtask

  task automatic t_submask();
    logic [7:0] d;
    wr(8'h24, 8'h01);
    rd(8'h24, d); check("R9 thermal mask readback", d, 8'h01);
    set_class(0, 8'h01);
    step(); step();
    rd(8'h23, d); check("R9 masked bit still latches", d, 8'h01);
    rd(8'h30, d); check("R9 masked bit hidden", d, 8'h00);
    check("R9 masked no irq", {7'd0, irq}, 8'h00);
    set_class(0, 8'h03);
    step();
    rd(8'h30, d); check("R9 open bit reaches main", d, 8'h01);
    cleanup();
    wr(8'h2C, 8'hFF);
    set_class(7, 8'hFF);
    step(); step();
    rd(8'h30, d); check("R9 system masked", d, 8'h00);
    rd(8'h2C, d); check("R9 system mask readback", d, 8'hFF);
    cleanup();
    wr(8'h2D, 8'hFF);
    rd(8'h2D, d); check("R10 unmapped reads zero", d, 8'h00);
    wr(8'h3F, 8'hFF);
    rd(8'h31, d); check("R10 unmapped write ignored", d, 8'h00);
    set_class(2, 8'h01);
    step(); step();
    rd(8'h30, d); check("R9 unmaskable class reports", d, 8'h04);
    check("R9 unmaskable class irq", {7'd0, irq}, 8'h01);
    cleanup();
  endtask

  task automatic t_mainmask();
    logic [7:0] d;
    fault_cond = {8{8'h01}};
    step(); step();
    wr(8'h31, 8'hFF);
    check("R4 all masked irq low", {7'd0, irq}, 8'h00);
    rd(8'h30, d); check("R11 status unchanged by mask", d, 8'hFF);
    rd(8'h31, d); check("R4 mask readback", d, 8'hFF);
    wr(8'h31, 8'hFB);
    check("R4 one class open", {7'd0, irq}, 8'h01);
    cleanup();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_pulse_ack();
    t_ack_held();
    t_sub_w1c();
    t_valid_src();
    t_bit_order();
    t_submask();
    t_mainmask();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule